// File: doc/BRIEF.md
# Memory Access Attribute Controller

This block turns the four per-access memory attributes (write-through, caching-inhibited, coherence-required, guarded) into the cache and bus actions for one access. A requester presents an access together with its kind (instruction fetch, load or store), a speculative flag, the source of its translation, the attribute bits from that source and the cache hit result. In the same cycle the block drives cache-update and cache-allocate enables, an uncached single-beat indication, a defer signal for speculative accesses to guarded memory, and a stall signal.

Stores that must reach external memory, either write-through or caching-inhibited, are each registered into a single-entry bus write port. The port holds address, data and a global/local qualifier until the bus acknowledges. Only one such write is in flight at a time, and stores are never merged on the bus. When translation is off for the access type, the block ignores the supplied attributes and applies a fixed default.

Top module: `mem_attr_ctrl`

## Requirements
- R1: When translation is disabled for the access type (`itrans_en` for fetches, `dtrans_en` for loads and stores), or the source is direct (`xlat_src`=2), the effective attributes are W=0, I=0, M=1, G=1. The supplied `attr_wimg` bits are ignored.
- R2: A fetch translated through a block entry (`req_kind`=0, `xlat_src`=0, `itrans_en`=1) is treated as unguarded whatever its G bit. A speculative fetch of this kind is therefore never deferred.
- R3: A store with W=1 that hits raises `cache_upd_en` in its request cycle. It also raises `bus_wr_req` in the following cycle, carrying the store's address and data.
- R4: Every accepted write-through or inhibited store produces its own bus write. Two stores to adjacent addresses appear as two separate requests, each with its own address and data.
- R5: `bus_wr_global` equals the effective M bit of the store that launched the pending write (1 = global, 0 = local).
- R6: A speculative access (`req_spec`=1) whose effective G=1 raises `access_defer`. It raises no cache enable, no uncached indication and no bus write. The same access without the flag proceeds.
- R7: With effective I=1, the block raises neither `cache_upd_en` nor `cache_alloc_en` and raises `uncached_single`. An inhibited store also issues a bus write.
- R8: A write-through store that misses raises no `cache_alloc_en`. It only issues the bus write.
- R9: A store with W=0, I=0 that hits raises `cache_upd_en` and launches no bus write.
- R10: A pending bus write stays asserted with stable address, data and qualifier until `bus_wr_ack`. While it is pending, any new store that needs the bus raises `access_stall` and has no effect, even in the cycle the acknowledge arrives.
- R11: The asynchronous active-high `rst` clears the pending bus write at once. While reset is held, all outputs are deasserted.
- R12: A cacheable access (I=0) that misses and is not a write-through store raises `cache_alloc_en`.

Attribute encoding: `attr_wimg[3]`=W, `[2]`=I, `[1]`=M, `[0]`=G. Kind encoding: 0 fetch, 1 load, 2 store. Source encoding: 0 block, 1 page, 2 direct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous active-high reset |
| req_valid | input | 1 | Access presented this cycle |
| req_kind | input | 2 | 0 fetch, 1 load, 2 store |
| req_spec | input | 1 | Access is speculative or a prefetch |
| xlat_src | input | 2 | 0 block, 1 page, 2 direct translation |
| itrans_en | input | 1 | Instruction translation enabled |
| dtrans_en | input | 1 | Data translation enabled |
| attr_wimg | input | 4 | Attributes from the translation source |
| cache_hit | input | 1 | Access hits in the cache |
| req_addr | input | ADDR_W | Store address |
| req_data | input | DATA_W | Store data |
| bus_wr_ack | input | 1 | Bus accepted the pending write |
| cache_upd_en | output | 1 | Write store data into the cache |
| cache_alloc_en | output | 1 | Allocate a line for this miss |
| uncached_single | output | 1 | Access bypasses the cache as one beat |
| access_defer | output | 1 | Guarded speculative access held off |
| access_stall | output | 1 | Store blocked by a pending bus write |
| bus_wr_req | output | 1 | Bus write pending |
| bus_wr_global | output | 1 | Pending write is global (1) or local (0) |
| bus_wr_addr | output | ADDR_W | Pending write address |
| bus_wr_data | output | DATA_W | Pending write data |

## Verification
The acknowledge that retires a pending bus write and a new write-through store can arrive in the same cycle. The bench provokes this by raising `bus_wr_ack` in the very cycle it presents a fresh write-through store. It then judges three things: that the store sees `access_stall` and no cache update, that the request drops on the next edge rather than being replaced, and that a retry of the store is then accepted as a distinct write. A second overlap, a speculative guarded access issued while a write is pending, is checked to defer without stalling and without disturbing the held request.

// File: rtl/mattr_pkg.sv
package mattr_pkg;

    typedef enum logic [1:0] {
        KIND_FETCH = 2'd0,
        KIND_LOAD  = 2'd1,
        KIND_STORE = 2'd2
    } acc_kind_e;

    typedef enum logic [1:0] {
        SRC_BLOCK  = 2'd0,
        SRC_PAGE   = 2'd1,
        SRC_DIRECT = 2'd2
    } xlat_src_e;

    typedef struct packed {
        logic w;
        logic i;
        logic m;
        logic g;
    } wimg_t;

    localparam wimg_t WIMG_UNTRANSLATED = '{w: 1'b0, i: 1'b0, m: 1'b1, g: 1'b1};

    typedef struct packed {
        logic upd;
        logic alloc;
        logic uncached;
        logic defer;
        logic stall;
        logic launch;
        logic global_q;
    } policy_t;

endpackage

// File: rtl/mattr_resolve.sv
module mattr_resolve
    import mattr_pkg::*;
(
    input  acc_kind_e kind,
    input  xlat_src_e src,
    input  logic      itrans_en,
    input  logic      dtrans_en,
    input  wimg_t     attr,
    output wimg_t     eff
);
    logic trans_on;

    always_comb begin
        trans_on = (kind == KIND_FETCH) ? itrans_en : dtrans_en;
        if (!trans_on || src == SRC_DIRECT) begin
            eff = WIMG_UNTRANSLATED;
        end else begin
            eff = attr;
            // block entries used for fetches carry no guard bit
            if (kind == KIND_FETCH && src == SRC_BLOCK) begin
                eff.g = 1'b0;
            end
        end
    end
endmodule

// File: rtl/mattr_policy.sv
module mattr_policy
    import mattr_pkg::*;
(
    input  logic      valid,
    input  acc_kind_e kind,
    input  logic      spec,
    input  logic      hit,
    input  wimg_t     eff,
    input  logic      wr_busy,
    output policy_t   pol
);
    logic is_store;
    logic needs_bus;
    logic go;

    always_comb begin
        is_store  = (kind == KIND_STORE);
        needs_bus = is_store && (eff.w || eff.i);
        pol       = '0;

        pol.defer = valid && spec && eff.g;
        pol.stall = valid && !pol.defer && needs_bus && wr_busy;
        go        = valid && !pol.defer && !pol.stall;

        pol.uncached = go && eff.i;
        pol.upd      = go && is_store && !eff.i && hit;
        pol.alloc    = go && !eff.i && !hit && !(is_store && eff.w);
        pol.launch   = go && needs_bus;
        pol.global_q = eff.m;
    end
endmodule

// File: rtl/mattr_wr_port.sv
module mattr_wr_port #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  logic              global_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    input  logic              ack,
    output logic              busy,
    output logic              global_out,
    output logic [ADDR_W-1:0] addr_out,
    output logic [DATA_W-1:0] data_out
);
    typedef struct packed {
        logic              pend;
        logic              glob;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } port_state_t;

    port_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.pend && ack) begin
            st_d.pend = 1'b0;
        end
        // launch is only granted while idle, so one write at a time
        if (launch && !st_q.pend) begin
            st_d.pend = 1'b1;
            st_d.glob = global_in;
            st_d.addr = addr_in;
            st_d.data = data_in;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy       = st_q.pend;
    assign global_out = st_q.pend && st_q.glob;
    assign addr_out   = st_q.addr;
    assign data_out   = st_q.data;
endmodule

// File: rtl/mem_attr_ctrl.sv
module mem_attr_ctrl
    import mattr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic              req_spec,
    input  logic [1:0]        xlat_src,
    input  logic              itrans_en,
    input  logic              dtrans_en,
    input  logic [3:0]        attr_wimg,
    input  logic              cache_hit,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic              bus_wr_ack,
    output logic              cache_upd_en,
    output logic              cache_alloc_en,
    output logic              uncached_single,
    output logic              access_defer,
    output logic              access_stall,
    output logic              bus_wr_req,
    output logic              bus_wr_global,
    output logic [ADDR_W-1:0] bus_wr_addr,
    output logic [DATA_W-1:0] bus_wr_data
);
    wimg_t   eff_attr;
    policy_t pol;
    logic    wr_busy;
    logic    valid_in;

    assign valid_in = req_valid && !rst;

    mattr_resolve u_resolve (
        .kind      (acc_kind_e'(req_kind)),
        .src       (xlat_src_e'(xlat_src)),
        .itrans_en (itrans_en),
        .dtrans_en (dtrans_en),
        .attr      (wimg_t'(attr_wimg)),
        .eff       (eff_attr)
    );

    mattr_policy u_policy (
        .valid   (valid_in),
        .kind    (acc_kind_e'(req_kind)),
        .spec    (req_spec),
        .hit     (cache_hit),
        .eff     (eff_attr),
        .wr_busy (wr_busy),
        .pol     (pol)
    );

    mattr_wr_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr_port (
        .clk        (clk),
        .rst        (rst),
        .launch     (pol.launch),
        .global_in  (pol.global_q),
        .addr_in    (req_addr),
        .data_in    (req_data),
        .ack        (bus_wr_ack),
        .busy       (wr_busy),
        .global_out (bus_wr_global),
        .addr_out   (bus_wr_addr),
        .data_out   (bus_wr_data)
    );

    assign cache_upd_en    = pol.upd;
    assign cache_alloc_en  = pol.alloc;
    assign uncached_single = pol.uncached;
    assign access_defer    = pol.defer;
    assign access_stall    = pol.stall;
    assign bus_wr_req      = wr_busy;
endmodule

// File: rtl/mem_attr_ctrl_chk.sv
module mem_attr_ctrl_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [1:0]        req_kind,
    input logic              req_spec,
    input logic [1:0]        xlat_src,
    input logic              itrans_en,
    input logic              dtrans_en,
    input logic              cache_upd_en,
    input logic              cache_alloc_en,
    input logic              uncached_single,
    input logic              access_defer,
    input logic              access_stall,
    input logic              bus_wr_req,
    input logic              bus_wr_ack,
    input logic              bus_wr_global,
    input logic [ADDR_W-1:0] bus_wr_addr,
    input logic [DATA_W-1:0] bus_wr_data
);
    // R10: a pending write is held unchanged until acknowledged
    a_r10_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
        bus_wr_req && !bus_wr_ack |=> bus_wr_req && $stable(bus_wr_addr)
            && $stable(bus_wr_data) && $stable(bus_wr_global));

    // R10: a stall only happens behind a pending write and does nothing
    a_r10_stall_inert: assert property (@(posedge clk) disable iff (rst)
        access_stall |-> bus_wr_req && !cache_upd_en && !cache_alloc_en && !uncached_single);

    // R6: a deferred access raises no cache or uncached action
    a_r6_defer_inert: assert property (@(posedge clk) disable iff (rst)
        access_defer |-> req_spec && !cache_upd_en && !cache_alloc_en && !uncached_single);

    // R6: a deferred access launches no bus write
    a_r6_defer_no_bus: assert property (@(posedge clk) disable iff (rst)
        access_defer && !bus_wr_req |=> !bus_wr_req);

    // R2: block-translated fetches are never deferred
    a_r2_iblock_unguarded: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_kind == 2'd0 && itrans_en && xlat_src == 2'd0 |-> !access_defer);

    // R1: an untranslated speculative load is guarded
    a_r1_forced_guard: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_kind == 2'd1 && !dtrans_en && req_spec |-> access_defer);

    // R11: reset leaves no pending write
    a_r11_reset_clear: assert property (@(posedge clk)
        rst |-> !bus_wr_req && !cache_upd_en && !cache_alloc_en);
endmodule

bind mem_attr_ctrl mem_attr_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .req_valid       (req_valid),
    .req_kind        (req_kind),
    .req_spec        (req_spec),
    .xlat_src        (xlat_src),
    .itrans_en       (itrans_en),
    .dtrans_en       (dtrans_en),
    .cache_upd_en    (cache_upd_en),
    .cache_alloc_en  (cache_alloc_en),
    .uncached_single (uncached_single),
    .access_defer    (access_defer),
    .access_stall    (access_stall),
    .bus_wr_req      (bus_wr_req),
    .bus_wr_ack      (bus_wr_ack),
    .bus_wr_global   (bus_wr_global),
    .bus_wr_addr     (bus_wr_addr),
    .bus_wr_data     (bus_wr_data)
);

// File: tb/mem_attr_ctrl_tb.sv
`timescale 1ns/100ps
module mem_attr_ctrl_tb;
    localparam int AW = 32;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          req_valid, req_spec, itrans_en, dtrans_en, cache_hit, bus_wr_ack;
    logic [1:0]    req_kind, xlat_src;
    logic [3:0]    attr_wimg;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_data;
    logic          cache_upd_en, cache_alloc_en, uncached_single, access_defer, access_stall;
    logic          bus_wr_req, bus_wr_global;
    logic [AW-1:0] bus_wr_addr;
    logic [DW-1:0] bus_wr_data;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    mem_attr_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_spec(req_spec), .xlat_src(xlat_src), .itrans_en(itrans_en),
        .dtrans_en(dtrans_en), .attr_wimg(attr_wimg), .cache_hit(cache_hit),
        .req_addr(req_addr), .req_data(req_data), .bus_wr_ack(bus_wr_ack),
        .cache_upd_en(cache_upd_en), .cache_alloc_en(cache_alloc_en),
        .uncached_single(uncached_single), .access_defer(access_defer),
        .access_stall(access_stall), .bus_wr_req(bus_wr_req),
        .bus_wr_global(bus_wr_global), .bus_wr_addr(bus_wr_addr),
        .bus_wr_data(bus_wr_data)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // present one access at a falling edge, settle, leave it driven
    task automatic issue(input logic [1:0] kind, input logic spec, input logic [1:0] src,
                         input logic [3:0] wimg, input logic hit,
                         input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_kind = kind; req_spec = spec; xlat_src = src;
        attr_wimg = wimg; cache_hit = hit; req_addr = a; req_data = d;
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0; bus_wr_ack = 1'b0;
        #1;
    endtask

    task automatic ack_once();
        @(negedge clk);
        req_valid = 1'b0; bus_wr_ack = 1'b1;
        @(negedge clk);
        bus_wr_ack = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        chk("R11 reset req", {63'd0, bus_wr_req}, 64'd0);
        chk("R11 reset enables", {62'd0, cache_upd_en, cache_alloc_en}, 64'd0);
    endtask

    task automatic t_wb_hit();
        issue(2'd2, 1'b0, 2'd1, 4'b0010, 1'b1, 32'h10, 32'h11);
        chk("R9 wb hit upd", {63'd0, cache_upd_en}, 64'd1);
        chk("R9 wb hit alloc", {63'd0, cache_alloc_en}, 64'd0);
        idle();
        chk("R9 wb hit no bus", {63'd0, bus_wr_req}, 64'd0);
    endtask

    task automatic t_load_miss();
        issue(2'd1, 1'b0, 2'd1, 4'b0010, 1'b0, 32'h20, 32'h0);
        chk("R12 load miss alloc", {63'd0, cache_alloc_en}, 64'd1);
        chk("R12 load miss uncached", {63'd0, uncached_single}, 64'd0);
        idle();
    endtask

    task automatic t_wt_hit_hold();
        issue(2'd2, 1'b0, 2'd1, 4'b1010, 1'b1, 32'h100, 32'hAA);
        chk("R3 wt hit upd", {63'd0, cache_upd_en}, 64'd1);
        idle();
        chk("R3 wt hit bus req", {63'd0, bus_wr_req}, 64'd1);
        chk("R3 wt hit addr", bus_wr_addr, 64'h100);
        chk("R3 wt hit data", bus_wr_data, 64'hAA);
        chk("R5 global", {63'd0, bus_wr_global}, 64'd1);
        for (int k = 0; k < 3; k++) idle();
        chk("R10 held req", {63'd0, bus_wr_req}, 64'd1);
        chk("R10 held addr", bus_wr_addr, 64'h100);
        // new write-through store while pending
        issue(2'd2, 1'b0, 2'd1, 4'b1010, 1'b1, 32'h104, 32'hBB);
        chk("R10 stall", {63'd0, access_stall}, 64'd1);
        chk("R10 stall no upd", {63'd0, cache_upd_en}, 64'd0);
        idle();
        chk("R10 stall kept addr", bus_wr_addr, 64'h100);
        ack_once();
        chk("R10 ack drops req", {63'd0, bus_wr_req}, 64'd0);
    endtask

    task automatic t_no_merge();
        int launches = 0;
        issue(2'd2, 1'b0, 2'd1, 4'b1000, 1'b0, 32'h200, 32'h1);
        chk("R8 wt miss no alloc", {63'd0, cache_alloc_en}, 64'd0);
        idle();
        if (bus_wr_req) launches++;
        chk("R8 wt miss bus", {63'd0, bus_wr_req}, 64'd1);
        chk("R5 local", {63'd0, bus_wr_global}, 64'd0);
        ack_once();
        issue(2'd2, 1'b0, 2'd1, 4'b1000, 1'b0, 32'h204, 32'h2);
        idle();
        if (bus_wr_req) launches++;
        chk("R4 second addr", bus_wr_addr, 64'h204);
        chk("R4 second data", bus_wr_data, 64'h2);
        chk("R4 two writes", 64'(launches), 64'd2);
        ack_once();
    endtask

    task automatic t_inhibit();
        issue(2'd1, 1'b0, 2'd1, 4'b0100, 1'b0, 32'h300, 32'h0);
        chk("R7 inh load alloc", {63'd0, cache_alloc_en}, 64'd0);
        chk("R7 inh load uncached", {63'd0, uncached_single}, 64'd1);
        issue(2'd2, 1'b0, 2'd1, 4'b0110, 1'b1, 32'h304, 32'h5);
        chk("R7 inh store upd", {63'd0, cache_upd_en}, 64'd0);
        idle();
        chk("R7 inh store bus", {63'd0, bus_wr_req}, 64'd1);
        ack_once();
    endtask

    task automatic t_guard();
        issue(2'd1, 1'b1, 2'd1, 4'b0001, 1'b0, 32'h400, 32'h0);
        chk("R6 defer", {63'd0, access_defer}, 64'd1);
        chk("R6 defer no alloc", {63'd0, cache_alloc_en}, 64'd0);
        issue(2'd2, 1'b1, 2'd1, 4'b1001, 1'b1, 32'h404, 32'h0);
        chk("R6 defer store upd", {63'd0, cache_upd_en}, 64'd0);
        idle();
        chk("R6 defer no bus", {63'd0, bus_wr_req}, 64'd0);
        issue(2'd1, 1'b0, 2'd1, 4'b0001, 1'b0, 32'h400, 32'h0);
        chk("R6 nonspec proceeds", {62'd0, access_defer, cache_alloc_en}, 64'd1);
        idle();
    endtask

    task automatic t_forced();
        dtrans_en = 1'b0; itrans_en = 1'b0;
        issue(2'd1, 1'b1, 2'd1, 4'b0000, 1'b0, 32'h500, 32'h0);
        chk("R1 forced guard", {63'd0, access_defer}, 64'd1);
        issue(2'd0, 1'b1, 2'd0, 4'b0000, 1'b0, 32'h500, 32'h0);
        chk("R1 forced fetch guard", {63'd0, access_defer}, 64'd1);
        issue(2'd2, 1'b0, 2'd1, 4'b1100, 1'b1, 32'h504, 32'h9);
        chk("R1 forced cacheable upd", {63'd0, cache_upd_en}, 64'd1);
        chk("R1 forced not inhibited", {63'd0, uncached_single}, 64'd0);
        idle();
        chk("R1 forced write-back", {63'd0, bus_wr_req}, 64'd0);
        dtrans_en = 1'b1; itrans_en = 1'b1;
        issue(2'd1, 1'b1, 2'd2, 4'b0000, 1'b0, 32'h508, 32'h0);
        chk("R1 direct source guard", {63'd0, access_defer}, 64'd1);
        idle();
    endtask

    task automatic t_iblock();
        issue(2'd0, 1'b1, 2'd0, 4'b0001, 1'b0, 32'h600, 32'h0);
        chk("R2 iblock no defer", {63'd0, access_defer}, 64'd0);
        chk("R2 iblock alloc", {63'd0, cache_alloc_en}, 64'd1);
        issue(2'd0, 1'b1, 2'd1, 4'b0001, 1'b0, 32'h600, 32'h0);
        chk("R2 page fetch guarded", {63'd0, access_defer}, 64'd1);
        idle();
    endtask

    task automatic t_collision();
        issue(2'd2, 1'b0, 2'd1, 4'b1010, 1'b0, 32'h700, 32'h7);
        idle();
        // guarded speculative while pending: defers, no stall
        issue(2'd1, 1'b1, 2'd1, 4'b0001, 1'b0, 32'h800, 32'h0);
        chk("R6 defer while pending", {62'd0, access_defer, access_stall}, 64'h2);
        @(negedge clk);
        bus_wr_ack = 1'b1; req_valid = 1'b1; req_kind = 2'd2; req_spec = 1'b0;
        attr_wimg = 4'b1010; cache_hit = 1'b1; req_addr = 32'h710; req_data = 32'h8;
        #1;
        chk("R10 stall on ack cycle", {63'd0, access_stall}, 64'd1);
        chk("R10 no upd on ack cycle", {63'd0, cache_upd_en}, 64'd0);
        idle();
        chk("R10 req dropped", {63'd0, bus_wr_req}, 64'd0);
        issue(2'd2, 1'b0, 2'd1, 4'b1010, 1'b1, 32'h710, 32'h8);
        chk("R10 retry accepted", {63'd0, cache_upd_en}, 64'd1);
        idle();
        chk("R4 retry addr", bus_wr_addr, 64'h710);
        ack_once();
    endtask

    task automatic t_reset_mid();
        issue(2'd2, 1'b0, 2'd1, 4'b1000, 1'b0, 32'h900, 32'h3);
        idle();
        chk("R11 pending before reset", {63'd0, bus_wr_req}, 64'd1);
        #0.5 rst = 1'b1;
        #0.5;
        chk("R11 async clear", {63'd0, bus_wr_req}, 64'd0);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R11 stays clear", {63'd0, bus_wr_req}, 64'd0);
    endtask

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_kind = 2'd1; req_spec = 1'b0; xlat_src = 2'd1;
        itrans_en = 1'b1; dtrans_en = 1'b1; attr_wimg = 4'b0; cache_hit = 1'b0;
        req_addr = '0; req_data = '0; bus_wr_ack = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst = 1'b0;
        t_wb_hit();
        t_load_miss();
        t_wt_hit_hold();
        t_no_merge();
        t_inhibit();
        t_guard();
        t_forced();
        t_iblock();
        t_collision();
        t_reset_mid();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule